// File: doc/BRIEF.md
# Track-Crossing Direction Detector

This block takes two already-binarized signals from an optical-disc front end and works out which way the pickup is crossing tracks. One input marks the mirror areas between tracks. The other is the zero-cross comparator output of the tracking error. Both inputs are synchronized into the block clock domain. The block then keeps a latched crossing level, a direction flag, and a gate for the switch that keeps direction-related components of the tracking error away from the actuator.

The crossing level is a copy of the mirror level, taken at every transition of the zero-cross signal in either direction. The direction flag records the zero-cross level each time the mirror signal rises. The two inputs are in quadrature, so that level tells the two directions apart. The suppression gate is on only when the crossing level is high and its enable bit is set.

One shared output pin can carry either the incoming defect flag or the direction flag. A select bit chooses which one.

Top module: `track_dir_detect`

## Requirements
- R1: While rstN is low, and after it is released before any input transition, coutOut, dirOut and suppressGate are all 0.
- R2: On a rising transition of zeroCrossIn, coutOut takes the level that mirrorIn has at that transition.
- R3: On a falling transition of zeroCrossIn, coutOut likewise takes the level that mirrorIn has at that transition.
- R4: coutOut holds its value while zeroCrossIn does not change, even when mirrorIn changes.
- R5: On a rising transition of mirrorIn, dirOut takes the level of zeroCrossIn. Level 1 means outward motion and level 0 means inward motion, from outer toward inner tracks.
- R6: dirOut holds its value on a falling transition of mirrorIn and whenever mirrorIn does not rise.
- R7: suppressGate is 1 exactly when coutOut is 1 and suppressEn is 1.
- R8: sharedOut equals defectIn when dirSelect is 0 and equals dirOut when dirSelect is 1.
- R9: Each input passes through a two-stage synchronizer and an edge detector. A transition is reflected on the outputs three clock edges after it is sampled, and transitions spaced two cycles apart are each seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low reset |
| mirrorIn | input | 1 | Binarized mirror-area signal |
| zeroCrossIn | input | 1 | Binarized tracking-error zero-cross signal |
| defectIn | input | 1 | Defect flag from the defect detector |
| dirSelect | input | 1 | Shared pin select: 0 defect, 1 direction |
| suppressEn | input | 1 | Control bit enabling the direction-suppression switch |
| coutOut | output | 1 | Latched crossing level |
| dirOut | output | 1 | Crossing direction, 1 outward |
| suppressGate | output | 1 | Direction-suppression switch enable |
| sharedOut | output | 1 | Defect or direction signal, per dirSelect |

## Verification
The inputs are stepped through a quadrature sequence in both directions. Each step changes either the mirror input alone or the zero-cross input alone. Mirror-only steps show that the crossing level ignores the mirror signal, while zero-cross steps in each direction show that it samples on both edges. A mirror rise with zero-cross low and another with it high separate the two direction codes, and a mirror fall shows that the direction holds. The enable and select bits are swept against both crossing levels and both defect levels, which separates a true AND and a true multiplexer from an output stuck at one operand.

// File: rtl/trk_dir_pkg.sv
package trk_dir_pkg;
  typedef struct packed {
    logic zcEdge;   // any transition of the synchronized zero-cross level
    logic mirRise;  // rising transition of the synchronized mirror level
  } edgeStrobe_t;
endpackage

// File: rtl/trkEdgeCtrl.sv
module trkEdgeCtrl
  import trk_dir_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        mirrorIn,
  input  logic        zeroCrossIn,
  output logic        mirLvl,
  output logic        zcLvl,
  output edgeStrobe_t strb
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] mirSh;
  logic [LAST:0] zcSh;
  logic          mirDly;
  logic          zcDly;

  generate
    if (SYNC_STAGES > 1) begin : gMulti
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          mirSh <= '0;
          zcSh  <= '0;
        end else begin
          mirSh <= {mirSh[LAST-1:0], mirrorIn};
          zcSh  <= {zcSh[LAST-1:0], zeroCrossIn};
        end
      end
    end else begin : gSingle
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          mirSh <= '0;
          zcSh  <= '0;
        end else begin
          mirSh <= mirrorIn;
          zcSh  <= zeroCrossIn;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mirDly <= 1'b0;
      zcDly  <= 1'b0;
    end else begin
      mirDly <= mirSh[LAST];
      zcDly  <= zcSh[LAST];
    end
  end

  assign mirLvl       = mirSh[LAST];
  assign zcLvl        = zcSh[LAST];
  assign strb.zcEdge  = zcSh[LAST] ^ zcDly;
  assign strb.mirRise = mirSh[LAST] & ~mirDly;
endmodule

// File: rtl/trkDirPath.sv
module trkDirPath
  import trk_dir_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  edgeStrobe_t strb,
  input  logic        mirLvl,
  input  logic        zcLvl,
  input  logic        defectIn,
  input  logic        dirSelect,
  input  logic        suppressEn,
  output logic        coutOut,
  output logic        dirOut,
  output logic        suppressGate,
  output logic        sharedOut
);
  logic coutQ;
  logic drtQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coutQ <= 1'b0;
    end else if (strb.zcEdge) begin
      coutQ <= mirLvl;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      drtQ <= 1'b0;
    end else if (strb.mirRise) begin
      drtQ <= zcLvl;
    end
  end

  assign coutOut      = coutQ;
  assign dirOut       = drtQ;
  assign suppressGate = coutQ & suppressEn;
  assign sharedOut    = dirSelect ? drtQ : defectIn;

  // R2 R3
  cout_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.zcEdge |=> coutQ == $past(mirLvl));

  // R4
  cout_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.zcEdge |=> $stable(coutQ));

  // R5
  dir_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.mirRise |=> drtQ == $past(zcLvl));

  // R6
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.mirRise |=> $stable(drtQ));
endmodule

// File: rtl/track_dir_detect.sv
module track_dir_detect
  import trk_dir_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic mirrorIn,
  input  logic zeroCrossIn,
  input  logic defectIn,
  input  logic dirSelect,
  input  logic suppressEn,
  output logic coutOut,
  output logic dirOut,
  output logic suppressGate,
  output logic sharedOut
);
  edgeStrobe_t strb;
  logic        mirLvl;
  logic        zcLvl;

  trkEdgeCtrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .mirrorIn(mirrorIn), .zeroCrossIn(zeroCrossIn),
    .mirLvl(mirLvl), .zcLvl(zcLvl), .strb(strb)
  );

  trkDirPath u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .mirLvl(mirLvl), .zcLvl(zcLvl),
    .defectIn(defectIn), .dirSelect(dirSelect), .suppressEn(suppressEn),
    .coutOut(coutOut), .dirOut(dirOut), .suppressGate(suppressGate),
    .sharedOut(sharedOut)
  );
endmodule

// File: tb/track_dir_detect_bench.sv
`timescale 1ns/1ps
module track_dir_detect_bench;
  typedef struct {
    logic  cout;
    logic  dir;
    logic  gate;
    logic  shared;
    string tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mirrorIn = 1'b0, zeroCrossIn = 1'b0, defectIn = 1'b0;
  logic dirSelect = 1'b0, suppressEn = 1'b0;
  logic coutOut, dirOut, suppressGate, sharedOut;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  expItem_t expQ[$];

  logic mCout = 1'b0, mDir = 1'b0, mMir = 1'b0, mZc = 1'b0;

  always #2 clk = ~clk;

  track_dir_detect u_track_dir_detect (
    .clk(clk), .rstN(rstN), .mirrorIn(mirrorIn), .zeroCrossIn(zeroCrossIn),
    .defectIn(defectIn), .dirSelect(dirSelect), .suppressEn(suppressEn),
    .coutOut(coutOut), .dirOut(dirOut), .suppressGate(suppressGate),
    .sharedOut(sharedOut)
  );

  task automatic cmp(input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", what, act, exp);
    end
  endtask

  // Driver: applies one input step, updates the reference model, queues the result.
  task automatic drive(input logic mir, input logic zc, input logic def,
                       input logic sel, input logic en, input int gap,
                       input bit check, input string tag);
    expItem_t it;
    @(negedge clk);
    if (zc !== mZc) mCout = mir;
    if (mir && !mMir) mDir = zc;
    mMir = mir; mZc = zc;
    mirrorIn = mir; zeroCrossIn = zc; defectIn = def;
    dirSelect = sel; suppressEn = en;
    repeat (gap) @(posedge clk);
    if (check) begin
      it.cout = mCout; it.dir = mDir; it.gate = mCout & en;
      it.shared = sel ? mDir : def; it.tag = tag;
      expQ.push_back(it);
    end
  endtask

  // Monitor: pops expected items and compares away from the clock edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        cmp({e.tag, " cout"}, coutOut, e.cout);
        cmp({e.tag, " dir"}, dirOut, e.dir);
        cmp({e.tag, " R7 gate"}, suppressGate, e.gate);
        cmp({e.tag, " R8 shared"}, sharedOut, e.shared);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    cmp("R1 reset cout", coutOut, 1'b0);
    cmp("R1 reset dir", dirOut, 1'b0);
    cmp("R1 reset gate", suppressGate, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    suppressEn = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    cmp("R1 after release gate", suppressGate, 1'b0);
    cmp("R1 after release cout", coutOut, 1'b0);

    drive(1, 0, 0, 1, 1, 4, 1, "R5 R4 inward rise");
    drive(1, 1, 0, 1, 1, 4, 1, "R2 zc rise");
    drive(0, 1, 1, 0, 1, 4, 1, "R6 R4 mirror fall");
    drive(0, 1, 1, 0, 0, 4, 1, "R7 enable off");
    drive(0, 0, 1, 1, 1, 4, 1, "R3 zc fall");
    drive(0, 1, 0, 0, 1, 4, 1, "R2 zc rise low mirror");
    drive(1, 1, 0, 1, 0, 4, 1, "R5 outward rise");
    drive(1, 0, 1, 0, 1, 4, 1, "R3 zc fall high mirror");
    drive(0, 0, 0, 1, 1, 4, 1, "R6 R4 mirror fall outward");
    // R9: steps two cycles apart, each must be seen
    drive(1, 0, 0, 1, 1, 2, 0, "R9");
    drive(1, 1, 0, 1, 1, 2, 0, "R9");
    drive(0, 1, 0, 1, 1, 2, 0, "R9");
    drive(0, 0, 0, 1, 1, 4, 1, "R9 fast inward burst");
    drive(0, 1, 0, 1, 1, 2, 0, "R9");
    drive(1, 1, 0, 1, 1, 2, 0, "R9");
    drive(1, 0, 0, 1, 1, 4, 1, "R9 fast outward burst");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule